// File: doc/BRIEF.md
# Cartridge CPU-Side Register Decoder and Program Banking

This block sits on the processor side of a cartridge bank-switching controller. It watches the processor address, data byte and write strobe, decodes writes into a small set of bank and control registers, and turns each processor address in the upper half of the map into an 18-bit program ROM address. It also drives the chip enable of an 8 KB work RAM at $6000-$7FFF, gated by a bit in the control byte.

Only address bits A15-A12 and A1-A0 take part in register selection, so every register appears at many mirrored addresses. A strap input swaps the roles of A0 and A1 before decoding, so one design serves two board variants that wire those two lines the other way round. The eight pattern-bank registers and the control byte are exported as plain vectors for the picture-side mapping logic. Writes landing in the sound and timer-interrupt ranges are not stored here; they only raise decoded strobes that carry the register index.

Top module: `cart_cpu_bank_dec`

## Requirements
- R1: Register selection uses only A15-A12 and A1-A0; any address acts exactly like (address AND $F003), so a write to $DE6A lands in the same register as a write to $D002.
- R2: When `swap_a01` is 1, A0 and A1 are exchanged before decoding: the register index is {A0,A1} instead of {A1,A0}, so a write to $D001 reaches pattern register 2 and a write to $D002 reaches register 1.
- R3: A write to page $8 (any index) stores data[3:0] as the 16 KB bank; for addresses $8000-$BFFF, `prg_addr` = {bank16, A13..A0}.
- R4: A write to page $C (any index) stores data[4:0] as the 8 KB bank; for addresses $C000-$DFFF, `prg_addr` = {bank8, A12..A0}.
- R5: For addresses $E000-$FFFF, `prg_addr` = {5'b11111, A12..A0}; for addresses below $8000, `prg_addr` is 0 and `prg_rom_ce` is low; `prg_rom_ce` equals A15.
- R6: A write to page $B with index 3 stores the whole byte as the control byte `ctrl_q`; `wram_ce` is 1 exactly when the address is in $6000-$7FFF and `ctrl_q[7]` is 1.
- R7: A write to page $D with index i stores the byte in pattern register i, and page $E with index i in register 4+i; register n occupies `chr_banks[8n+7:8n]`. The stored value is exactly the data byte and is visible from the cycle after the write edge.
- R8: `snd_wr` is 1 in the same cycle as `cpu_wr` for writes to pages $9 and $A (any index) and page $B with index 0-2; `snd_page` is A13..A12 and `snd_idx` is the decoded index.
- R9: `irq_wr` is 1 in the same cycle as `cpu_wr` for writes to page $F with index 0-2 (0 latch, 1 control, 2 acknowledge), with `irq_idx` the decoded index; index 3 raises no strobe.
- R10: Reset (active-low `rst_n`) clears every register to zero, so `ctrl_q`, `chr_banks` and both bank registers read 0 and `wram_ce` is low.
- R11: Without `cpu_wr` no register changes and no strobe is raised, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_data | input | 8 | Processor write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| swap_a01 | input | 1 | Board strap: exchange A0 and A1 before decoding |
| prg_addr | output | 18 | Program ROM address |
| prg_rom_ce | output | 1 | Program ROM chip enable ($8000-$FFFF) |
| wram_ce | output | 1 | Work RAM chip enable |
| ctrl_q | output | 8 | Stored control byte |
| chr_banks | output | 64 | Eight pattern-bank registers, register n at bits 8n+7:8n |
| snd_wr | output | 1 | Sound-range write strobe |
| snd_page | output | 2 | Sound page (A13..A12) |
| snd_idx | output | 2 | Sound register index after strap |
| irq_wr | output | 1 | Interrupt-timer write strobe |
| irq_idx | output | 2 | Interrupt-timer register index after strap |

## Verification
The two functions that share a cycle are register writing and address translation: a write to page $8 or $C is issued while the same address sits on the bus, so `prg_addr` in the write cycle must still show the old bank and switch to the new one only after the edge. The bench provokes this on purpose and also hits it constantly in the random phase, where every write is followed by translations of random addresses in each window, all compared against a bench model. Likewise a write to page $B index 3 must change `wram_ce` for a following RAM-range access while raising no sound strobe in its own cycle.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

    localparam int DATA_W       = 8;
    localparam int CHR_PER_PAGE = 4;
    localparam int CHR_REGS     = 2 * CHR_PER_PAGE;
    localparam int IDX_W        = 2;
    localparam logic [IDX_W-1:0] CTRL_IDX = 2'd3;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_BANK16,
        RG_SND,
        RG_SNDCTL,
        RG_BANK8,
        RG_CHR_LO,
        RG_CHR_HI,
        RG_IRQ
    } region_e;

    function automatic region_e region_of(input logic [3:0] pg);
        region_e r;
        case (pg)
            4'h8:    r = RG_BANK16;
            4'h9:    r = RG_SND;
            4'hA:    r = RG_SND;
            4'hB:    r = RG_SNDCTL;
            4'hC:    r = RG_BANK8;
            4'hD:    r = RG_CHR_LO;
            4'hE:    r = RG_CHR_HI;
            4'hF:    r = RG_IRQ;
            default: r = RG_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cbd_addr_norm.sv
module cbd_addr_norm
    import cbd_pkg::*;
(
    input  logic [3:0]       page_bits,
    input  logic [1:0]       low_bits,
    input  logic             swap_a01,
    output region_e          region,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        region = region_of(page_bits);
        if (swap_a01) begin
            idx = {low_bits[0], low_bits[1]};
        end else begin
            idx = low_bits;
        end
    end
endmodule

// File: rtl/cbd_reg_file.sv
module cbd_reg_file
    import cbd_pkg::*;
#(
    parameter int B16_W = 4,
    localparam int B8_W = B16_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  region_e                    region,
    input  logic [IDX_W-1:0]           idx,
    input  logic [DATA_W-1:0]          data,
    output logic [B16_W-1:0]           bank16,
    output logic [B8_W-1:0]            bank8,
    output logic [DATA_W-1:0]          ctrl,
    output logic [CHR_REGS*DATA_W-1:0] chr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank16 <= '0;
            bank8  <= '0;
            ctrl   <= '0;
        end else if (wr) begin
            if (region == RG_BANK16) bank16 <= data[B16_W-1:0];
            if (region == RG_BANK8)  bank8  <= data[B8_W-1:0];
            if (region == RG_SNDCTL && idx == CTRL_IDX) ctrl <= data;
        end
    end

    for (genvar i = 0; i < CHR_REGS; i++) begin : g_chr
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(i % CHR_PER_PAGE);
        localparam region_e HOME = (i < CHR_PER_PAGE) ? RG_CHR_LO : RG_CHR_HI;
        logic hit;
        assign hit = wr && (region == HOME) && (idx == SLOT);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chr[i*DATA_W +: DATA_W] <= '0;
            end else if (hit) begin
                chr[i*DATA_W +: DATA_W] <= data;
            end
        end
    end
endmodule

// File: rtl/cbd_prg_map.sv
module cbd_prg_map #(
    parameter int B16_W = 4,
    localparam int B8_W   = B16_W + 1,
    localparam int PRG_AW = 14 + B16_W
) (
    input  logic [15:0]       addr,
    input  logic [B16_W-1:0]  bank16,
    input  logic [B8_W-1:0]   bank8,
    input  logic              ram_en,
    output logic [PRG_AW-1:0] prg_addr,
    output logic              rom_ce,
    output logic              ram_ce
);
    always_comb begin
        case (addr[15:13])
            3'b100, 3'b101: prg_addr = {bank16, addr[13:0]};
            3'b110:         prg_addr = {bank8, addr[12:0]};
            3'b111:         prg_addr = {{B8_W{1'b1}}, addr[12:0]};
            default:        prg_addr = '0;
        endcase
        rom_ce = addr[15];
        ram_ce = (addr[15:13] == 3'b011) && ram_en;
    end
endmodule

// File: rtl/cbd_strobe.sv
module cbd_strobe
    import cbd_pkg::*;
(
    input  logic             wr,
    input  region_e          region,
    input  logic [1:0]       page_lo,
    input  logic [IDX_W-1:0] idx,
    output logic             snd_wr,
    output logic [1:0]       snd_page,
    output logic [IDX_W-1:0] snd_idx,
    output logic             irq_wr,
    output logic [IDX_W-1:0] irq_idx
);
    always_comb begin
        snd_wr   = wr && ((region == RG_SND) ||
                          (region == RG_SNDCTL && idx != CTRL_IDX));
        snd_page = page_lo;
        snd_idx  = idx;
        irq_wr   = wr && (region == RG_IRQ) && (idx != CTRL_IDX);
        irq_idx  = idx;
    end
endmodule

// File: rtl/cart_cpu_bank_dec.sv
module cart_cpu_bank_dec
    import cbd_pkg::*;
#(
    parameter int B16_W = 4,
    localparam int B8_W   = B16_W + 1,
    localparam int PRG_AW = 14 + B16_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [15:0]                cpu_addr,
    input  logic [DATA_W-1:0]          cpu_data,
    input  logic                       cpu_wr,
    input  logic                       swap_a01,
    output logic [PRG_AW-1:0]          prg_addr,
    output logic                       prg_rom_ce,
    output logic                       wram_ce,
    output logic [DATA_W-1:0]          ctrl_q,
    output logic [CHR_REGS*DATA_W-1:0] chr_banks,
    output logic                       snd_wr,
    output logic [1:0]                 snd_page,
    output logic [IDX_W-1:0]           snd_idx,
    output logic                       irq_wr,
    output logic [IDX_W-1:0]           irq_idx
);
    region_e          region;
    logic [IDX_W-1:0] idx;
    logic [B16_W-1:0] bank16;
    logic [B8_W-1:0]  bank8;

    cbd_addr_norm u_norm (
        .page_bits (cpu_addr[15:12]),
        .low_bits  (cpu_addr[1:0]),
        .swap_a01  (swap_a01),
        .region    (region),
        .idx       (idx)
    );

    cbd_reg_file #(.B16_W(B16_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cpu_wr),
        .region (region),
        .idx    (idx),
        .data   (cpu_data),
        .bank16 (bank16),
        .bank8  (bank8),
        .ctrl   (ctrl_q),
        .chr    (chr_banks)
    );

    cbd_prg_map #(.B16_W(B16_W)) u_prg (
        .addr     (cpu_addr),
        .bank16   (bank16),
        .bank8    (bank8),
        .ram_en   (ctrl_q[DATA_W-1]),
        .prg_addr (prg_addr),
        .rom_ce   (prg_rom_ce),
        .ram_ce   (wram_ce)
    );

    cbd_strobe u_strb (
        .wr       (cpu_wr),
        .region   (region),
        .page_lo  (cpu_addr[13:12]),
        .idx      (idx),
        .snd_wr   (snd_wr),
        .snd_page (snd_page),
        .snd_idx  (snd_idx),
        .irq_wr   (irq_wr),
        .irq_idx  (irq_idx)
    );
endmodule

// File: rtl/cbd_checker.sv
module cbd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_data,
    input logic        cpu_wr,
    input logic        swap_a01,
    input logic [17:0] prg_addr,
    input logic        wram_ce,
    input logic [7:0]  ctrl_q,
    input logic [63:0] chr_banks,
    input logic        snd_wr,
    input logic        irq_wr
);
    logic [1:0] bus_idx;
    assign bus_idx = swap_a01 ? {cpu_addr[0], cpu_addr[1]} : cpu_addr[1:0];

    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q == 8'h00 && chr_banks == 64'h0));

    assert_hold_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |=> ($stable(chr_banks) && $stable(ctrl_q)));

    assert_chr0_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:12] == 4'hD && bus_idx == 2'd0)
        |=> chr_banks[7:0] == $past(cpu_data));

    assert_ctrl_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:12] == 4'hB && bus_idx == 2'd3)
        |=> ctrl_q == $past(cpu_data));

    assert_wram_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[7] |-> !wram_ce);

    assert_fixed_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b111) |-> prg_addr[17:13] == 5'h1F);

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wr |-> (cpu_wr && cpu_addr[15:12] == 4'hF && bus_idx != 2'd3));

    assert_snd_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        snd_wr |-> (cpu_wr && !irq_wr));
endmodule

bind cart_cpu_bank_dec cbd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_data  (cpu_data),
    .cpu_wr    (cpu_wr),
    .swap_a01  (swap_a01),
    .prg_addr  (prg_addr),
    .wram_ce   (wram_ce),
    .ctrl_q    (ctrl_q),
    .chr_banks (chr_banks),
    .snd_wr    (snd_wr),
    .irq_wr    (irq_wr)
);

// File: tb/cart_cpu_bank_dec_bench.sv
module cart_cpu_bank_dec_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_wr = 1'b0;
    logic        swap_a01 = 1'b0;
    logic [17:0] prg_addr;
    logic        prg_rom_ce, wram_ce, snd_wr, irq_wr;
    logic [7:0]  ctrl_q;
    logic [63:0] chr_banks;
    logic [1:0]  snd_page, snd_idx, irq_idx;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [3:0]  m16 = '0;
    logic [4:0]  m8 = '0;
    logic [7:0]  mctrl = '0;
    logic [63:0] mchr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cart_cpu_bank_dec u_cart_cpu_bank_dec (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .swap_a01(swap_a01), .prg_addr(prg_addr),
        .prg_rom_ce(prg_rom_ce), .wram_ce(wram_ce), .ctrl_q(ctrl_q),
        .chr_banks(chr_banks), .snd_wr(snd_wr), .snd_page(snd_page),
        .snd_idx(snd_idx), .irq_wr(irq_wr), .irq_idx(irq_idx)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] nidx(input logic [15:0] a, input logic sw);
        return sw ? {a[0], a[1]} : a[1:0];
    endfunction

    function automatic logic [17:0] exp_prg(input logic [15:0] a);
        if (a[15:14] == 2'b10) return {m16, a[13:0]};
        if (a[15:13] == 3'b110) return {m8, a[12:0]};
        if (a[15:13] == 3'b111) return {5'h1F, a[12:0]};
        return 18'h0;
    endfunction

    task automatic model_write(input logic [15:0] a, input logic [7:0] d, input logic sw);
        logic [1:0] i;
        i = nidx(a, sw);
        case (a[15:12])
            4'h8: m16 = d[3:0];
            4'hC: m8 = d[4:0];
            4'hB: if (i == 2'd3) mctrl = d;
            4'hD: mchr[{1'b0, i}*8 +: 8] = d;
            4'hE: mchr[{1'b1, i}*8 +: 8] = d;
            default: ;
        endcase
    endtask

    // one write; strobes are judged inside the write cycle (R8, R9)
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic sw);
        logic [1:0] i;
        logic es, ei;
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1; swap_a01 = sw;
        #1;
        i  = nidx(a, sw);
        es = (a[15:12] == 4'h9) || (a[15:12] == 4'hA) || (a[15:12] == 4'hB && i != 2'd3);
        ei = (a[15:12] == 4'hF) && (i != 2'd3);
        chk("R8 snd_wr", 64'(snd_wr), 64'(es));
        if (es) chk("R8 snd_page/idx", {60'h0, snd_page, snd_idx}, {60'h0, a[13:12], i});
        chk("R9 irq_wr", 64'(irq_wr), 64'(ei));
        if (ei) chk("R9 irq_idx", 64'(irq_idx), 64'(i));
        // old bank still drives the translation in the write cycle
        chk("R3 R4 prg during write", 64'(prg_addr), 64'(exp_prg(a)));
        @(negedge clk);
        cpu_wr = 1'b0;
        model_write(a, d, sw);
    endtask

    task automatic probe(input logic [15:0] a);
        cpu_addr = a;
        #1;
        chk("R3 R4 R5 prg_addr", 64'(prg_addr), 64'(exp_prg(a)));
        chk("R5 prg_rom_ce", 64'(prg_rom_ce), 64'(a[15]));
        chk("R6 wram_ce", 64'(wram_ce), 64'((a[15:13] == 3'b011) && mctrl[7]));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] a;
        logic [7:0]  d;
        logic [3:0]  pg;
        process::self().srandom(32'd1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10 ctrl_q", 64'(ctrl_q), 64'h0);
        chk("R10 chr_banks", chr_banks, 64'h0);
        cpu_addr = 16'h6000; #1;
        chk("R10 wram_ce", 64'(wram_ce), 64'h0);
        cpu_addr = 16'h8123; #1;
        chk("R10 bank16 zero", 64'(prg_addr), 64'h00123);
        rst_n = 1'b1;

        // R1: $DE6A mirrors $D002
        bus_write(16'hDE6A, 8'h5A, 1'b0);
        chk("R1 mirror DE6A->reg2", 64'(chr_banks[23:16]), 64'h5A);
        // R2: strap swaps index 1 and 2
        bus_write(16'hD001, 8'hC3, 1'b1);
        chk("R2 swap D001->reg2", 64'(chr_banks[23:16]), 64'hC3);
        chk("R2 reg1 untouched", 64'(chr_banks[15:8]), 64'h00);
        bus_write(16'hE002, 8'h77, 1'b1);
        chk("R2 swap E002->reg5", 64'(chr_banks[47:40]), 64'h77);
        // R3, R4: same-cycle write then translation
        bus_write(16'h8003, 8'hFB, 1'b0);
        probe(16'hBFFF);
        bus_write(16'hC7F1, 8'hEE, 1'b0);
        probe(16'hDABC);
        probe(16'hE001);
        probe(16'h7FFF);
        // R6: RAM enable set and cleared; index 3 on page B gives no sound strobe
        bus_write(16'hB003, 8'hA0, 1'b0);
        chk("R6 ctrl_q", 64'(ctrl_q), 64'hA0);
        probe(16'h6ABC);
        bus_write(16'hBFF3, 8'h20, 1'b0);
        probe(16'h7000);
        // R9: index 3 on page F raises nothing
        bus_write(16'hF003, 8'h11, 1'b0);
        bus_write(16'hF001, 8'h22, 1'b1);
        // R11: bus activity without write strobe changes nothing
        @(negedge clk);
        cpu_addr = 16'hD000; cpu_data = 8'h99; swap_a01 = 1'b0;
        #1;
        chk("R11 no snd/irq strobe", {62'h0, snd_wr, irq_wr}, 64'h0);
        @(negedge clk);
        cpu_addr = 16'hB003; #1;
        @(negedge clk);
        chk("R11 chr unchanged", chr_banks, mchr);
        chk("R11 ctrl unchanged", 64'(ctrl_q), 64'(mctrl));

        // random phase
        for (int n = 0; n < 400; n++) begin
            case ($urandom_range(0, 9))
                0: pg = 4'h8; 1: pg = 4'h9; 2: pg = 4'hA; 3: pg = 4'hB;
                4: pg = 4'hC; 5: pg = 4'hD; 6: pg = 4'hE; 7: pg = 4'hF;
                8: pg = 4'h6; default: pg = 4'(($urandom_range(0, 5)));
            endcase
            a = {pg, 12'($urandom)};
            d = 8'($urandom);
            bus_write(a, d, 1'($urandom));
            chk("R7 R1 R2 chr_banks", chr_banks, mchr);
            chk("R6 ctrl_q", 64'(ctrl_q), 64'(mctrl));
            probe({2'b10, 14'($urandom)});
            probe({3'b110, 13'($urandom)});
            probe({3'b011, 13'($urandom)});
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule